// File: doc/BRIEF.md
# Register-Programmed Raster Timing Generator

The block produces the horizontal and vertical timing of a video raster: line and frame sync, a border window and a display window. A host programs it with single 32-bit writes. Bits 31:24 of the word select a register and the low `W` bits carry its value. Every horizontal value is stored as the real position minus a fixed pipeline offset, so the value written differs from the pixel position by a constant.

Writes land in a staging set. The whole staging set, including the control and sync-polarity registers, is copied into the active set in the clock on which the frame wraps. The raster therefore never shows a frame built from a mix of old and new settings.

In interlaced mode a field flag toggles on every frame. On odd fields the vertical sync starts and ends at a mid-line position taken from a register. The sync outputs can run at either polarity, or both can carry a composite sync.

Top module: `raster_timing_gen`

## Requirements
- R1: A write with selector 0x80+k (horizontal) or 0x90+k (vertical) loads staging slot k from bits W-1:0. The slots are k=0 cycle, 1 sync, 2 border start, 3 display start, 4 display end, 5 border end, 6 reserved and 7 mid-line position. Selector 0xE0 loads control and 0xC0 loads sync style. Slot 6 and every other selector leave all outputs unchanged.
- R2: A line lasts horizontal cycle + 8 clocks.
- R3: Horizontal sync is asserted for the first horizontal sync + 8 clocks of each line.
- R4: The border is active for line positions [border start + 12, border end + 12). The display is active for line positions [display start + 18, display end + 18).
- R5: A progressive frame lasts vertical cycle + 2 lines, and vertical sync covers lines [0, vertical sync + 1). Border is the horizontal border window ANDed with lines [vertical border start + 1, vertical border end + 1). Display is the horizontal display window ANDed with lines [vertical display start + 1, vertical display end + 1).
- R6: Writes take effect only from the first clock of the next frame. The frame in progress keeps its old timing, polarity and control values.
- R7: Control bits 2:0 hold a bits-per-pixel code n, meaning 2^n bits per pixel for n from 0 to 5, and the code drives `bpp_code_o`. Control bit 3 enables interlace.
- R8: With interlace enabled, `field_o` toggles at each frame start; with interlace disabled it is 0. While `field_o` is 1, vertical sync rises on line 0 and falls on line vertical sync + 1, both at line position = horizontal slot 7.
- R9: Sync-style bit 0 inverts horizontal sync and bit 1 inverts vertical sync. Bit 2 selects composite mode, in which both outputs carry (hsync XOR vsync), inverted when bit 0 is set.
- R10: While reset is asserted all outputs are 0 and every register is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Selector in bits 31:24, value in the low bits |
| hsync_o | output | 1 | Horizontal sync, or composite sync |
| vsync_o | output | 1 | Vertical sync, or composite sync |
| border_o | output | 1 | Border window active |
| display_o | output | 1 | Display window active |
| field_o | output | 1 | Interlace field, aligned with the other outputs |
| bpp_code_o | output | 3 | Active bits-per-pixel code |

## Verification
The assertions check four properties on every cycle: the line counter never passes its programmed end and returns to 0 after it, the line number moves only when a line ends, and the active registers and the field flag change only at a frame start. The assertions also check that the field stays 0 while interlace is off. Only the bench scenarios can show the exact positions of the sync, border and display edges, and they compare whole frames sample by sample against a model. The bench scenarios also show that a write made mid-frame leaves the current frame alone and applies to the next one, and they cover the odd-field mid-line vertical sync, the polarity and composite styles, and writes to unused selectors.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int unsigned NREG = 8;

  typedef enum logic [2:0] {
    RI_CYCLE  = 3'd0,
    RI_SYNC   = 3'd1,
    RI_BSTART = 3'd2,
    RI_DSTART = 3'd3,
    RI_DEND   = 3'd4,
    RI_BEND   = 3'd5,
    RI_RSVD   = 3'd6,
    RI_MID    = 3'd7
  } reg_idx_e;

  localparam logic [7:0] SEL_H_BASE = 8'h80;
  localparam logic [7:0] SEL_V_BASE = 8'h90;
  localparam logic [7:0] SEL_CTRL   = 8'hE0;
  localparam logic [7:0] SEL_STYLE  = 8'hC0;

  // stored value + offset = real position
  localparam int unsigned H_CYCLE_OFS  = 8;
  localparam int unsigned H_SYNC_OFS   = 8;
  localparam int unsigned H_BORDER_OFS = 12;
  localparam int unsigned H_DISP_OFS   = 18;
  localparam int unsigned V_CYCLE_OFS  = 2;
  localparam int unsigned V_EDGE_OFS   = 1;

  typedef struct packed {
    logic       ilace;
    logic [2:0] bpp;
  } ctrl_t;

  typedef struct packed {
    logic csync;
    logic vs_low;
    logic hs_low;
  } style_t;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [31:0]             wr_data_i,
  input  logic                    load_i,
  output logic [NREG-1:0][W-1:0]  h_act_o,
  output logic [NREG-1:0][W-1:0]  v_act_o,
  output ctrl_t                   ctrl_act_o,
  output style_t                  style_act_o,
  output ctrl_t                   ctrl_stg_o
);
  logic [7:0]            sel;
  logic [W-1:0]          val;
  logic [NREG-1:0][W-1:0] h_stg, v_stg;
  style_t                style_stg;
  logic                  unused_wr_bits;

  assign sel = wr_data_i[31:24];
  assign val = wr_data_i[W-1:0];
  assign unused_wr_bits = ^wr_data_i[23:W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_stg      <= '0;
      v_stg      <= '0;
      ctrl_stg_o <= '0;
      style_stg  <= '0;
    end else if (wr_en_i) begin
      for (int k = 0; k < NREG; k++) begin
        if (sel == SEL_H_BASE + 8'(k)) h_stg[k] <= val;
        if (sel == SEL_V_BASE + 8'(k)) v_stg[k] <= val;
      end
      if (sel == SEL_CTRL)  ctrl_stg_o <= ctrl_t'(wr_data_i[3:0]);
      if (sel == SEL_STYLE) style_stg  <= style_t'(wr_data_i[2:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_act_o     <= '0;
      v_act_o     <= '0;
      ctrl_act_o  <= '0;
      style_act_o <= '0;
    end else if (load_i) begin
      h_act_o     <= h_stg;
      v_act_o     <= v_stg;
      ctrl_act_o  <= ctrl_stg_o;
      style_act_o <= style_stg;
    end
  end
endmodule

// File: rtl/rtg_hcount.sv
module rtg_hcount
  import rtg_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cycle_i,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] bstart_i,
  input  logic [W-1:0] bend_i,
  input  logic [W-1:0] dstart_i,
  input  logic [W-1:0] dend_i,
  input  logic [W-1:0] mid_i,
  output logic [W:0]   hcnt_o,
  output logic [W:0]   hend_o,
  output logic         line_end_o,
  output logic         hs_o,
  output logic         hb_o,
  output logic         hd_o,
  output logic         past_mid_o
);
  localparam int unsigned CW = W + 1;

  logic [CW-1:0] sync_lim, b_lo, b_hi, d_lo, d_hi;

  assign hend_o   = CW'(cycle_i) + CW'(H_CYCLE_OFS - 1);
  assign sync_lim = CW'(sync_i) + CW'(H_SYNC_OFS);
  assign b_lo     = CW'(bstart_i) + CW'(H_BORDER_OFS);
  assign b_hi     = CW'(bend_i) + CW'(H_BORDER_OFS);
  assign d_lo     = CW'(dstart_i) + CW'(H_DISP_OFS);
  assign d_hi     = CW'(dend_i) + CW'(H_DISP_OFS);

  assign line_end_o = (hcnt_o == hend_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hcnt_o <= '0;
    else if (line_end_o) hcnt_o <= '0;
    else                 hcnt_o <= hcnt_o + 1'b1;
  end

  assign hs_o       = (hcnt_o < sync_lim);
  assign hb_o       = (hcnt_o >= b_lo) && (hcnt_o < b_hi);
  assign hd_o       = (hcnt_o >= d_lo) && (hcnt_o < d_hi);
  assign past_mid_o = (hcnt_o >= CW'(mid_i));
endmodule

// File: rtl/rtg_vcount.sv
module rtg_vcount
  import rtg_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         line_end_i,
  input  logic         odd_i,
  input  logic         past_mid_i,
  input  logic [W-1:0] cycle_i,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] bstart_i,
  input  logic [W-1:0] bend_i,
  input  logic [W-1:0] dstart_i,
  input  logic [W-1:0] dend_i,
  output logic [W:0]   vcnt_o,
  output logic         frame_end_o,
  output logic         vs_o,
  output logic         vb_o,
  output logic         vd_o
);
  localparam int unsigned CW = W + 1;

  logic [CW-1:0] vend, sync_lim, b_lo, b_hi, d_lo, d_hi;
  logic          vs_even, vs_odd;

  assign vend     = CW'(cycle_i) + CW'(V_CYCLE_OFS - 1);
  assign sync_lim = CW'(sync_i) + CW'(V_EDGE_OFS);
  assign b_lo     = CW'(bstart_i) + CW'(V_EDGE_OFS);
  assign b_hi     = CW'(bend_i) + CW'(V_EDGE_OFS);
  assign d_lo     = CW'(dstart_i) + CW'(V_EDGE_OFS);
  assign d_hi     = CW'(dend_i) + CW'(V_EDGE_OFS);

  assign frame_end_o = (vcnt_o == vend);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         vcnt_o <= '0;
    else if (line_end_i) vcnt_o <= frame_end_o ? '0 : vcnt_o + 1'b1;
  end

  // odd field: sync window shifted by half a line
  assign vs_even = (vcnt_o < sync_lim);
  assign vs_odd  = (vs_even && ((vcnt_o != '0) || past_mid_i)) ||
                   ((vcnt_o == sync_lim) && !past_mid_i);
  assign vs_o    = odd_i ? vs_odd : vs_even;
  assign vb_o    = (vcnt_o >= b_lo) && (vcnt_o < b_hi);
  assign vd_o    = (vcnt_o >= d_lo) && (vcnt_o < d_hi);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic        hsync_o,
  output logic        vsync_o,
  output logic        border_o,
  output logic        display_o,
  output logic        field_o,
  output logic [2:0]  bpp_code_o
);
  logic [NREG-1:0][W-1:0] h_act, v_act;
  ctrl_t                  ctrl_act, ctrl_stg;
  style_t                 style_act;
  logic [W:0]             hcnt, hend, vcnt;
  logic                   line_end, frame_end, frame_start;
  logic                   hs, hb, hd, past_mid, vs, vb, vd;
  logic                   field_q, csync, hs_style, vs_style;
  logic [W-1:0]           h_cycle_a;
  logic                   ilace_a;
  logic                   unused_slots;

  assign frame_start  = line_end & frame_end;
  assign h_cycle_a    = h_act[RI_CYCLE];
  assign ilace_a      = ctrl_act.ilace;
  assign unused_slots = ^{h_act[RI_RSVD], v_act[RI_RSVD], v_act[RI_MID]};

  rtg_regs #(.W(W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .load_i      (frame_start),
    .h_act_o     (h_act),
    .v_act_o     (v_act),
    .ctrl_act_o  (ctrl_act),
    .style_act_o (style_act),
    .ctrl_stg_o  (ctrl_stg)
  );

  rtg_hcount #(.W(W)) u_hcnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cycle_i    (h_act[RI_CYCLE]),
    .sync_i     (h_act[RI_SYNC]),
    .bstart_i   (h_act[RI_BSTART]),
    .bend_i     (h_act[RI_BEND]),
    .dstart_i   (h_act[RI_DSTART]),
    .dend_i     (h_act[RI_DEND]),
    .mid_i      (h_act[RI_MID]),
    .hcnt_o     (hcnt),
    .hend_o     (hend),
    .line_end_o (line_end),
    .hs_o       (hs),
    .hb_o       (hb),
    .hd_o       (hd),
    .past_mid_o (past_mid)
  );

  rtg_vcount #(.W(W)) u_vcnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_end_i  (line_end),
    .odd_i       (field_q),
    .past_mid_i  (past_mid),
    .cycle_i     (v_act[RI_CYCLE]),
    .sync_i      (v_act[RI_SYNC]),
    .bstart_i    (v_act[RI_BSTART]),
    .bend_i      (v_act[RI_BEND]),
    .dstart_i    (v_act[RI_DSTART]),
    .dend_i      (v_act[RI_DEND]),
    .vcnt_o      (vcnt),
    .frame_end_o (frame_end),
    .vs_o        (vs),
    .vb_o        (vb),
    .vd_o        (vd)
  );

  // field follows the staged interlace bit, loaded at the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          field_q <= 1'b0;
    else if (frame_start) field_q <= ctrl_stg.ilace ? ~field_q : 1'b0;
  end

  assign csync    = hs ^ vs;
  assign hs_style = (style_act.csync ? csync : hs) ^ style_act.hs_low;
  assign vs_style = style_act.csync ? (csync ^ style_act.hs_low) : (vs ^ style_act.vs_low);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_o   <= 1'b0;
      vsync_o   <= 1'b0;
      border_o  <= 1'b0;
      display_o <= 1'b0;
      field_o   <= 1'b0;
    end else begin
      hsync_o   <= hs_style;
      vsync_o   <= vs_style;
      border_o  <= hb & vb;
      display_o <= hd & vd;
      field_o   <= field_q;
    end
  end

  assign bpp_code_o = ctrl_act.bpp;
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
  parameter int unsigned W = 12
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         frame_start_i,
  input logic         line_end_i,
  input logic         field_i,
  input logic         ilace_i,
  input logic [W:0]   hcnt_i,
  input logic [W:0]   hend_i,
  input logic [W:0]   vcnt_i,
  input logic [W-1:0] h_cycle_i
);
  a_r2_hcnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcnt_i <= hend_i);

  a_r2_line_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_end_i |=> (hcnt_i == '0));

  a_r5_vcnt_per_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_end_i |=> $stable(vcnt_i));

  a_r6_regs_at_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(h_cycle_i));

  a_r8_field_at_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(field_i));

  a_r8_prog_field_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ilace_i |-> !field_i);
endmodule

bind raster_timing_gen rtg_checker #(.W(W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_start_i (frame_start),
  .line_end_i    (line_end),
  .field_i       (field_q),
  .ilace_i       (ilace_a),
  .hcnt_i        (hcnt),
  .hend_i        (hend),
  .vcnt_i        (vcnt),
  .h_cycle_i     (h_cycle_a)
);

// File: tb/raster_timing_gen_test.sv
module raster_timing_gen_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        hsync_o, vsync_o, border_o, display_o, field_o;
  logic [2:0]  bpp_code_o;

  int nchk = 0;
  int nfail = 0;

  // bench model of the programmed raster
  int m_hc, m_hsw, m_hbs, m_hbe, m_hds, m_hde, m_hi;
  int m_vc, m_vsw, m_vbs, m_vbe, m_vds, m_vde;
  int m_style;

  always #5 clk_i = ~clk_i;

  raster_timing_gen uut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .hsync_o    (hsync_o),
    .vsync_o    (vsync_o),
    .border_o   (border_o),
    .display_o  (display_o),
    .field_o    (field_o),
    .bpp_code_o (bpp_code_o)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] sel, input int val);
    wr_en_i   = 1'b1;
    wr_data_i = {sel, 24'(val)};
    @(negedge clk_i);
    wr_en_i   = 1'b0;
    wr_data_i = '0;
  endtask

  // expected {hs, vs, border, display} at line position h, line v
  function automatic logic [3:0] exp_out(input int h, input int v, input int fld);
    logic hs, vs, bd, dp, cs, ho, vo;
    int vsl;
    vsl = m_vsw + 1;
    hs  = (h < m_hsw + 8);
    if (fld == 0) vs = (v < vsl);
    else vs = ((v < vsl) && (v != 0 || h >= m_hi)) || (v == vsl && h < m_hi);
    bd = (h >= m_hbs + 12) && (h < m_hbe + 12) && (v >= m_vbs + 1) && (v < m_vbe + 1);
    dp = (h >= m_hds + 18) && (h < m_hde + 18) && (v >= m_vds + 1) && (v < m_vde + 1);
    cs = hs ^ vs;
    if (m_style[2]) begin
      ho = cs ^ m_style[0];
      vo = ho;
    end else begin
      ho = hs ^ m_style[0];
      vo = vs ^ m_style[1];
    end
    return {ho, vo, bd, dp};
  endfunction

  // entered at the falling edge of frame sample 0; leaves at sample 0 of the next frame
  task automatic capture(input string tag, input int fld);
    int hp, vp, n;
    int bad [5];
    int fa [5];
    int fe [5];
    logic [4:0] a, e;
    hp = m_hc + 8;
    vp = m_vc + 2;
    n  = hp * vp;
    for (int s = 0; s < 5; s++) bad[s] = 0;
    for (int i = 0; i < n; i++) begin
      e = {exp_out(i % hp, i / hp, fld), fld[0]};
      a = {hsync_o, vsync_o, border_o, display_o, field_o};
      for (int s = 0; s < 5; s++) begin
        if (a[4-s] !== e[4-s]) begin
          if (bad[s] == 0) begin fa[s] = int'(a[4-s]); fe[s] = int'(e[4-s]); end
          bad[s]++;
        end
      end
      @(negedge clk_i);
    end
    check(bad[0] == 0, {tag, " R2 R3 R9 hsync_o sequence"}, bad[0] ? fa[0] : 0, bad[0] ? fe[0] : 0);
    check(bad[1] == 0, {tag, " R5 R8 R9 vsync_o sequence"}, bad[1] ? fa[1] : 0, bad[1] ? fe[1] : 0);
    check(bad[2] == 0, {tag, " R4 R5 border_o sequence"}, bad[2] ? fa[2] : 0, bad[2] ? fe[2] : 0);
    check(bad[3] == 0, {tag, " R4 R5 display_o sequence"}, bad[3] ? fa[3] : 0, bad[3] ? fe[3] : 0);
    check(bad[4] == 0, {tag, " R8 field_o level"}, bad[4] ? fa[4] : 0, bad[4] ? fe[4] : 0);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk_i);
    check(hsync_o == 0 && vsync_o == 0, "R10 sync outputs low in reset", int'({hsync_o, vsync_o}), 0);
    check(border_o == 0 && display_o == 0, "R10 windows low in reset", int'({border_o, display_o}), 0);
    check(field_o == 0 && bpp_code_o == 0, "R10 field and bpp zero in reset", int'({field_o, bpp_code_o}), 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_program_base();
    m_hc = 40; m_hsw = 4; m_hbs = 8; m_hds = 4; m_hde = 22; m_hbe = 30; m_hi = 20;
    m_vc = 6;  m_vsw = 1; m_vbs = 2; m_vds = 2; m_vde = 5;  m_vbe = 5;  m_style = 0;
    wr(8'h80, m_hc);  wr(8'h81, m_hsw); wr(8'h82, m_hbs); wr(8'h83, m_hds);
    wr(8'h84, m_hde); wr(8'h85, m_hbe); wr(8'h87, m_hi);
    wr(8'h90, m_vc);  wr(8'h91, m_vsw); wr(8'h92, m_vbs); wr(8'h93, m_vds);
    wr(8'h94, m_vde); wr(8'h95, m_vbe);
    repeat (1000) @(negedge clk_i);
    @(posedge vsync_o);
    @(negedge clk_i);
    capture("base R1", 0);
  endtask

  task automatic t_ignored_selectors();
    fork
      capture("ignored R1", 0);
      begin
        repeat (3) @(negedge clk_i);
        wr(8'h86, 12'h0FF); wr(8'h96, 12'h0FF); wr(8'h88, 3); wr(8'h55, 100); wr(8'hA0, 1);
      end
    join
    capture("after ignored R1", 0);
  endtask

  task automatic t_frame_apply();
    fork
      capture("old frame kept R6", 0);
      begin
        repeat (5) @(negedge clk_i);
        wr(8'h80, 56); wr(8'h87, 28); wr(8'h91, 2); wr(8'h84, 30);
      end
    join
    m_hc = 56; m_hi = 28; m_vsw = 2; m_hde = 30;
    capture("new frame R6", 0);
  endtask

  task automatic t_control();
    fork
      capture("bpp write R7", 0);
      begin
        repeat (4) @(negedge clk_i);
        wr(8'hE0, 3);
        @(negedge clk_i);
        check(bpp_code_o == 0, "R6 R7 bpp code held until frame start", int'(bpp_code_o), 0);
      end
    join
    check(bpp_code_o == 3, "R7 bpp code after frame start", int'(bpp_code_o), 3);
    capture("bpp applied R7", 0);
  endtask

  task automatic t_style(input int sty, input string tag);
    fork
      capture({tag, " old"}, 0);
      begin
        repeat (4) @(negedge clk_i);
        wr(8'hC0, sty);
      end
    join
    m_style = sty;
    capture(tag, 0);
  endtask

  task automatic t_interlace();
    fork
      capture("before interlace R8", 0);
      begin
        repeat (4) @(negedge clk_i);
        wr(8'hE0, 8 | 3);
      end
    join
    capture("field one R8", 1);
    capture("field zero R8", 0);
    fork
      capture("field one again R8", 1);
      begin
        repeat (4) @(negedge clk_i);
        wr(8'hE0, 3);
      end
    join
    capture("progressive after interlace R8", 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    nchk++;
    nfail++;
    $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    t_program_base();
    t_ignored_selectors();
    t_frame_apply();
    t_control();
    t_style(3, "inverted R9");
    t_style(4, "composite high R9");
    t_style(5, "composite low R9");
    t_style(0, "plain R9");
    t_interlace();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule